// File: doc/BRIEF.md
# Static-Bus to Wishbone Bridge

This block lets an external processor with an asynchronous static-memory bus reach memories and peripherals that live inside an FPGA. The processor drives a byte address, a transfer size, write data and three active-low strobes (chip select, output enable and write enable). The bridge brings the strobes into its own clock domain and decodes which 64 MB chip-select bank the address falls in. It then runs one Wishbone classic cycle on one of two master ports: a memory port for banks 0 to 4 and a peripheral I/O port for bank 5.

While that cycle runs, the bridge holds the processor with a wait request. When the slave acknowledges, or when a fixed number of clocks passes without an acknowledge, the bridge ends the cycle and gives the processor a one-clock ready pulse. Each port has a parameter for its slave data width (1, 2 or 4 bytes). The bridge steers bytes and byte selects to suit that width and returns read data right-justified and zero-extended.

The processor's clock output is the bridge clock passed straight through. The interrupt line is also passed through unchanged.

Top module: `sbw_bridge`

## Requirements
- R1: An access whose address bits [31:26] are 0x10 to 0x14 (banks 0 to 4, 0x4000_0000 to 0x53FF_FFFF) runs a cycle on the memory port only.
- R2: An access with address bits [31:26] equal to 0x15 (bank 5) runs a cycle on the I/O port only. Any other address starts no Wishbone cycle. It still completes with a ready pulse, and a read of it returns zero.
- R3: The Wishbone address of either port is the 30-bit word address, equal to processor address bits [31:2].
- R4: An access starts when the synchronized chip select is low together with output enable (read) or write enable (write). CYC and STB of the chosen port then rise together on the third rising clock edge after the strobes go low. While CYC is high, address, data, select and write enable do not change, and the two ports are never active at once.
- R5: The wait output is high exactly while a cycle is in flight. The ready output is high for exactly one clock, beginning at the edge where CYC drops.
- R6: An acknowledge sampled while CYC is high ends the cycle: CYC and STB are low after the next rising edge.
- R7: If no acknowledge arrives during TIMEOUT (default 16) consecutive clocks of CYC, the cycle is abandoned after exactly TIMEOUT clocks, and a read that timed out returns all-zero data.
- R8: On a 4-byte port the size code (0 byte, 1 halfword, 2 or 3 word) and address bits [1:0] (offset o) select n = min(size bytes, 4 - o) lanes. SEL is ((1<<n)-1)<<o, write data is shifted up by 8*o bytes-bits, and read data is shifted down by 8*o with bits above 8*n cleared.
- R9: On a 1- or 2-byte port the offset is ignored. n = min(size bytes, port bytes), SEL is the low n bits, write data sits in the low n bytes with the other bytes zero, and read data is the low n bytes zero-extended. The default I/O port is 2 bytes wide.
- R10: The clock output equals the bridge clock, and the interrupt output equals the interrupt input.
- R11: After an access completes, no new cycle starts until the synchronized chip select has gone high.
- R12: Read data is updated only when a read completes. It holds its value through writes and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge and Wishbone clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_o | output | 1 | Clock to the processor (same as clk) |
| ext_cs_n | input | 1 | Processor chip select, active low, asynchronous |
| ext_oe_n | input | 1 | Processor output enable (read), active low, asynchronous |
| ext_we_n | input | 1 | Processor write enable, active low, asynchronous |
| ext_addr | input | 32 | Processor byte address |
| ext_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 or 3 word |
| ext_wdata | input | 32 | Right-justified write data |
| ext_rdata | output | 32 | Right-justified, zero-extended read data |
| ext_wait | output | 1 | Wait request, high while a cycle is in flight |
| ext_ready | output | 1 | One-clock completion pulse |
| irq_i | input | 1 | Interrupt from the FPGA side |
| ext_irq_o | output | 1 | Interrupt to the processor |
| mem_cyc_o | output | 1 | Memory port CYC |
| mem_stb_o | output | 1 | Memory port STB |
| mem_we_o | output | 1 | Memory port write enable |
| mem_adr_o | output | 30 | Memory port word address |
| mem_sel_o | output | 4 | Memory port byte selects |
| mem_dat_o | output | 32 | Memory port write data |
| mem_dat_i | input | 32 | Memory port read data |
| mem_ack_i | input | 1 | Memory port acknowledge |
| io_cyc_o | output | 1 | I/O port CYC |
| io_stb_o | output | 1 | I/O port STB |
| io_we_o | output | 1 | I/O port write enable |
| io_adr_o | output | 30 | I/O port word address |
| io_sel_o | output | 4 | I/O port byte selects |
| io_dat_o | output | 32 | I/O port write data |
| io_dat_i | input | 32 | I/O port read data |
| io_ack_i | input | 1 | I/O port acknowledge |

## Verification
The strobes take two synchronizer edges and one decision edge to reach the bus. CYC is therefore due on the third rising edge after the strobes fall. CYC drops, and ready and read data appear, on the edge that samples the acknowledge (or the TIMEOUT-th edge of CYC). Ready falls one edge later. The bench drives every input and the slave acknowledges on falling edges. A behavioural model steps on each rising edge, and all outputs are compared against it on the following falling edge. Each cycle's latency is also counted and checked against the expected acknowledge delay or the timeout.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_DONE = 2'd2, ST_REL = 2'd3} sbw_state_e;
  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_MEM = 2'd1, TGT_IO = 2'd2} sbw_tgt_e;

  // bytes requested by a size code
  function automatic int req_bytes(input logic [1:0] size);
    case (size)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // lane offset honoured only by a full-width port
  function automatic int lane_off(input logic [1:0] off, input int pbytes);
    return (pbytes == BUS_BYTES) ? int'(off) : 0;
  endfunction

  // lanes actually moved: request clipped to what the port offers
  function automatic int eff_bytes(input logic [1:0] size, input logic [1:0] off, input int pbytes);
    int room;
    int req;
    room = pbytes - lane_off(off, pbytes);
    req  = req_bytes(size);
    return (req < room) ? req : room;
  endfunction

  function automatic logic [BUS_BYTES-1:0] lane_sel(input logic [1:0] size, input logic [1:0] off,
                                                     input int pbytes);
    logic [BUS_BYTES-1:0] m;
    int o;
    int n;
    o = lane_off(off, pbytes);
    n = eff_bytes(size, off, pbytes);
    m = '0;
    for (int i = 0; i < BUS_BYTES; i++) m[i] = (i >= o) && (i < o + n);
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] lane_wdat(input logic [BUS_W-1:0] wdata, input logic [1:0] size,
                                                  input logic [1:0] off, input int pbytes);
    logic [BUS_W-1:0]     d;
    logic [BUS_BYTES-1:0] m;
    int o;
    o = lane_off(off, pbytes);
    m = lane_sel(size, off, pbytes);
    d = '0;
    for (int i = 0; i < BUS_BYTES; i++)
      if (m[i]) d[8*i +: 8] = wdata[8*((i - o) & (BUS_BYTES - 1)) +: 8];
    return d;
  endfunction

  function automatic logic [BUS_W-1:0] lane_rdat(input logic [BUS_W-1:0] din, input logic [1:0] size,
                                                  input logic [1:0] off, input int pbytes);
    logic [BUS_W-1:0] r;
    int o;
    int n;
    o = lane_off(off, pbytes);
    n = eff_bytes(size, off, pbytes);
    r = '0;
    for (int k = 0; k < BUS_BYTES; k++)
      if (k < n) r[8*k +: 8] = din[8*((k + o) % BUS_BYTES) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sbw_bank_dec.sv
module sbw_bank_dec
  import sbw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BANK_SHIFT = 26,
  parameter int BASE_BANK  = 16,
  parameter int MEM_BANKS  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output sbw_tgt_e          tgt
);
  localparam int SEL_W  = ADDR_W - BANK_SHIFT;
  localparam int NBANKS = MEM_BANKS + 1;
  localparam int IO_IDX = MEM_BANKS;

  logic [SEL_W-1:0]  bank_field;
  logic [NBANKS-1:0] hit;

  assign bank_field = addr[ADDR_W-1:BANK_SHIFT];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign hit[b] = (bank_field == SEL_W'(BASE_BANK + b));
  end

  always_comb begin
    if (|hit[MEM_BANKS-1:0]) tgt = TGT_MEM;
    else if (hit[IO_IDX])    tgt = TGT_IO;
    else                     tgt = TGT_NONE;
  end
endmodule

// File: rtl/sbw_wb_port.sv
module sbw_wb_port
  import sbw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PORT_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 finish,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic [BUS_W-1:0]     wdata,
  input  logic                 we,
  output logic                 cyc_o,
  output logic                 stb_o,
  output logic                 we_o,
  output logic [ADDR_W-3:0]    adr_o,
  output logic [BUS_BYTES-1:0] sel_o,
  output logic [BUS_W-1:0]     dat_o,
  input  logic [BUS_W-1:0]     dat_i,
  output logic [BUS_W-1:0]     rdata
);
  logic [1:0] off_src;
  logic [1:0] size_q;
  logic [1:0] off_q;

  if (PORT_BYTES == BUS_BYTES) begin : g_wide
    assign off_src = addr[1:0];
  end else begin : g_narrow
    assign off_src = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_o  <= 1'b0;
      we_o   <= 1'b0;
      adr_o  <= '0;
      sel_o  <= '0;
      dat_o  <= '0;
      size_q <= '0;
      off_q  <= '0;
    end else if (start) begin
      cyc_o  <= 1'b1;
      we_o   <= we;
      adr_o  <= addr[ADDR_W-1:2];
      sel_o  <= lane_sel(size, off_src, PORT_BYTES);
      dat_o  <= we ? lane_wdat(wdata, size, off_src, PORT_BYTES) : '0;
      size_q <= size;
      off_q  <= off_src;
    end else if (finish) begin
      cyc_o <= 1'b0;
    end
  end

  assign stb_o = cyc_o;
  assign rdata = lane_rdat(dat_i, size_q, off_q, PORT_BYTES);
endmodule

// File: rtl/sbw_bridge.sv
module sbw_bridge
  import sbw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TIMEOUT    = 16,
  parameter int MEM_BYTES  = 4,
  parameter int IO_BYTES   = 2,
  parameter int BANK_SHIFT = 26,
  parameter int BASE_BANK  = 16,
  parameter int MEM_BANKS  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 ext_clk_o,
  input  logic                 ext_cs_n,
  input  logic                 ext_oe_n,
  input  logic                 ext_we_n,
  input  logic [ADDR_W-1:0]    ext_addr,
  input  logic [1:0]           ext_size,
  input  logic [BUS_W-1:0]     ext_wdata,
  output logic [BUS_W-1:0]     ext_rdata,
  output logic                 ext_wait,
  output logic                 ext_ready,
  input  logic                 irq_i,
  output logic                 ext_irq_o,
  output logic                 mem_cyc_o,
  output logic                 mem_stb_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-3:0]    mem_adr_o,
  output logic [BUS_BYTES-1:0] mem_sel_o,
  output logic [BUS_W-1:0]     mem_dat_o,
  input  logic [BUS_W-1:0]     mem_dat_i,
  input  logic                 mem_ack_i,
  output logic                 io_cyc_o,
  output logic                 io_stb_o,
  output logic                 io_we_o,
  output logic [ADDR_W-3:0]    io_adr_o,
  output logic [BUS_BYTES-1:0] io_sel_o,
  output logic [BUS_W-1:0]     io_dat_o,
  input  logic [BUS_W-1:0]     io_dat_i,
  input  logic                 io_ack_i
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic       cs_s, oe_s, we_s;
  sbw_tgt_e   tgt_dec, tgt_q;
  sbw_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic       we_q;
  logic [BUS_W-1:0] rdata_q, mem_rd, io_rd;

  // named internal events
  logic access_req, start_mem, start_io, start_none;
  logic ack_sel, ack_evt, tmo_evt, rd_tmo_evt, finish;

  assign ext_clk_o = clk;
  assign ext_irq_o = irq_i;

  sbw_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ext_cs_n, ext_oe_n, ext_we_n}),
    .q    ({cs_s, oe_s, we_s})
  );

  sbw_bank_dec #(
    .ADDR_W(ADDR_W), .BANK_SHIFT(BANK_SHIFT), .BASE_BANK(BASE_BANK), .MEM_BANKS(MEM_BANKS)
  ) u_dec (
    .addr(ext_addr),
    .tgt (tgt_dec)
  );

  assign access_req = (state_q == ST_IDLE) && !cs_s && (!oe_s || !we_s);
  assign start_mem  = access_req && (tgt_dec == TGT_MEM);
  assign start_io   = access_req && (tgt_dec == TGT_IO);
  assign start_none = access_req && (tgt_dec == TGT_NONE);

  assign ack_sel    = (tgt_q == TGT_MEM) ? mem_ack_i : io_ack_i;
  assign ack_evt    = (state_q == ST_BUSY) && ack_sel;
  assign tmo_evt    = (state_q == ST_BUSY) && !ack_sel && (cnt_q == CNT_W'(TIMEOUT - 1));
  assign rd_tmo_evt = tmo_evt && !we_q;
  assign finish     = ack_evt || tmo_evt;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_none) state_d = ST_DONE;
               else if (start_mem || start_io) state_d = ST_BUSY;
      ST_BUSY: if (finish) state_d = ST_DONE;
      ST_DONE: state_d = ST_REL;
      ST_REL:  if (cs_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= TGT_NONE;
      we_q    <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (access_req) begin
        tgt_q <= tgt_dec;
        we_q  <= !we_s;
        cnt_q <= '0;
        if (start_none && we_s) rdata_q <= '0;
      end else if (state_q == ST_BUSY) begin
        if (ack_evt) begin
          if (!we_q) rdata_q <= (tgt_q == TGT_MEM) ? mem_rd : io_rd;
        end else if (rd_tmo_evt) begin
          rdata_q <= '0;
        end else if (!tmo_evt) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  sbw_wb_port #(.ADDR_W(ADDR_W), .PORT_BYTES(MEM_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n), .start(start_mem),
    .finish(finish && (tgt_q == TGT_MEM)),
    .addr(ext_addr), .size(ext_size), .wdata(ext_wdata), .we(!we_s),
    .cyc_o(mem_cyc_o), .stb_o(mem_stb_o), .we_o(mem_we_o), .adr_o(mem_adr_o),
    .sel_o(mem_sel_o), .dat_o(mem_dat_o), .dat_i(mem_dat_i), .rdata(mem_rd)
  );

  sbw_wb_port #(.ADDR_W(ADDR_W), .PORT_BYTES(IO_BYTES)) u_io (
    .clk(clk), .rst_n(rst_n), .start(start_io),
    .finish(finish && (tgt_q == TGT_IO)),
    .addr(ext_addr), .size(ext_size), .wdata(ext_wdata), .we(!we_s),
    .cyc_o(io_cyc_o), .stb_o(io_stb_o), .we_o(io_we_o), .adr_o(io_adr_o),
    .sel_o(io_sel_o), .dat_o(io_dat_o), .dat_i(io_dat_i), .rdata(io_rd)
  );

  assign ext_rdata = rdata_q;
  assign ext_wait  = (state_q == ST_BUSY);
  assign ext_ready = (state_q == ST_DONE);
endmodule

// File: rtl/sbw_checks.sv
module sbw_checks #(
  parameter int TIMEOUT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_cyc_o,
  input logic        mem_stb_o,
  input logic        mem_we_o,
  input logic [29:0] mem_adr_o,
  input logic [3:0]  mem_sel_o,
  input logic [31:0] mem_dat_o,
  input logic        mem_ack_i,
  input logic        io_cyc_o,
  input logic        io_stb_o,
  input logic        io_we_o,
  input logic [29:0] io_adr_o,
  input logic [3:0]  io_sel_o,
  input logic [31:0] io_dat_o,
  input logic        io_ack_i,
  input logic        ext_wait,
  input logic        ext_ready,
  input logic [31:0] ext_rdata,
  input logic        rd_tmo_evt
);
  logic any_cyc;
  int   run;

  assign any_cyc = mem_cyc_o || io_cyc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= 0;
    else if (any_cyc) run <= run + 1;
    else              run <= 0;
  end

  assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_cyc_o && io_cyc_o));

  assert_cyc_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc_o == mem_stb_o) && (io_cyc_o == io_stb_o));

  assert_mem_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc_o && $past(mem_cyc_o)) |->
      ($stable(mem_adr_o) && $stable(mem_sel_o) && $stable(mem_dat_o) && $stable(mem_we_o)));

  assert_io_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cyc_o && $past(io_cyc_o)) |->
      ($stable(io_adr_o) && $stable(io_sel_o) && $stable(io_dat_o) && $stable(io_we_o)));

  assert_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wait == any_cyc);

  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |=> !ext_ready);

  assert_ready_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_cyc) |-> ext_ready);

  assert_mem_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc_o && mem_ack_i) |=> !mem_cyc_o);

  assert_io_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cyc_o && io_ack_i) |=> !io_cyc_o);

  assert_tmo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_cyc |-> (run < TIMEOUT));

  assert_tmo_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tmo_evt |=> (ext_rdata == 32'd0));
endmodule

bind sbw_bridge sbw_checks #(.TIMEOUT(TIMEOUT)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .mem_cyc_o(mem_cyc_o), .mem_stb_o(mem_stb_o), .mem_we_o(mem_we_o), .mem_adr_o(mem_adr_o),
  .mem_sel_o(mem_sel_o), .mem_dat_o(mem_dat_o), .mem_ack_i(mem_ack_i),
  .io_cyc_o(io_cyc_o), .io_stb_o(io_stb_o), .io_we_o(io_we_o), .io_adr_o(io_adr_o),
  .io_sel_o(io_sel_o), .io_dat_o(io_dat_o), .io_ack_i(io_ack_i),
  .ext_wait(ext_wait), .ext_ready(ext_ready), .ext_rdata(ext_rdata), .rd_tmo_evt(rd_tmo_evt)
);

// File: tb/test_sbw_bridge.sv
`timescale 1ns/1ps
module test_sbw_bridge;
  localparam int TMO   = 16;
  localparam int MEM_P = 4;
  localparam int IO_P  = 2;
  localparam int NEVER = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_cs_n = 1'b1, ext_oe_n = 1'b1, ext_we_n = 1'b1;
  logic [31:0] ext_addr = '0, ext_wdata = '0;
  logic [1:0]  ext_size = '0;
  logic irq_i = 1'b0;
  logic [31:0] mem_dat_i = '0, io_dat_i = '0;
  logic mem_ack_i = 1'b0, io_ack_i = 1'b0;
  logic ext_clk_o, ext_wait, ext_ready, ext_irq_o;
  logic [31:0] ext_rdata;
  logic mem_cyc_o, mem_stb_o, mem_we_o, io_cyc_o, io_stb_o, io_we_o;
  logic [29:0] mem_adr_o, io_adr_o;
  logic [3:0]  mem_sel_o, io_sel_o;
  logic [31:0] mem_dat_o, io_dat_o;

  always #10 clk = ~clk;

  sbw_bridge i_sbw_bridge (
    .clk(clk), .rst_n(rst_n), .ext_clk_o(ext_clk_o),
    .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
    .ext_addr(ext_addr), .ext_size(ext_size), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_wait(ext_wait), .ext_ready(ext_ready), .irq_i(irq_i), .ext_irq_o(ext_irq_o),
    .mem_cyc_o(mem_cyc_o), .mem_stb_o(mem_stb_o), .mem_we_o(mem_we_o), .mem_adr_o(mem_adr_o),
    .mem_sel_o(mem_sel_o), .mem_dat_o(mem_dat_o), .mem_dat_i(mem_dat_i), .mem_ack_i(mem_ack_i),
    .io_cyc_o(io_cyc_o), .io_stb_o(io_stb_o), .io_we_o(io_we_o), .io_adr_o(io_adr_o),
    .io_sel_o(io_sel_o), .io_dat_o(io_dat_o), .io_dat_i(io_dat_i), .io_ack_i(io_ack_i)
  );

  int vectors = 0, errors = 0;
  int mem_lat = 0, io_lat = 0, mem_cc = 0, io_cc = 0;
  int run_len = 0, last_run = 0, starts = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent lane arithmetic
  function automatic int b_n(input logic [1:0] sz, input logic [1:0] off, input int p);
    int req, o;
    req = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    o   = (p == 4) ? int'(off) : 0;
    return (req < p - o) ? req : p - o;
  endfunction
  function automatic logic [3:0] b_sel(input logic [1:0] sz, input logic [1:0] off, input int p);
    int o;
    o = (p == 4) ? int'(off) : 0;
    return 4'((((64'd1 << b_n(sz, off, p)) - 1)) << o);
  endfunction
  function automatic logic [31:0] b_wd(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] off, input int p);
    longint unsigned m;
    int o;
    o = (p == 4) ? int'(off) : 0;
    m = ((64'd1 << (8 * b_n(sz, off, p))) - 1) << (8 * o);
    return 32'((64'(w) << (8 * o)) & m);
  endfunction
  function automatic logic [31:0] b_rd(input logic [31:0] d, input logic [1:0] sz, input logic [1:0] off, input int p);
    longint unsigned m;
    int o;
    o = (p == 4) ? int'(off) : 0;
    m = (64'd1 << (8 * b_n(sz, off, p))) - 1;
    return 32'((64'(d) >> (8 * o)) & m);
  endfunction

  // behavioural model, stepped on every rising edge
  int m_st = 0, m_cnt = 0, m_tgt = 0;
  bit m_we = 0;
  logic [31:0] m_addr = '0, m_wd = '0, m_rd = '0;
  logic [1:0]  m_sz = '0;
  logic [2:0]  syn1 = 3'b111, syn2 = 3'b111;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_tgt = 0; m_we = 0; m_rd = '0;
      syn1 = 3'b111; syn2 = 3'b111;
    end else begin
      if (m_st == 0) begin
        if (!syn2[2] && (!syn2[1] || !syn2[0])) begin
          int bank;
          bank   = int'(ext_addr[31:26]) - 16;
          m_we   = !syn2[0];
          m_addr = ext_addr; m_sz = ext_size; m_wd = ext_wdata;
          m_tgt  = (bank >= 0 && bank <= 4) ? 1 : (bank == 5) ? 2 : 0;
          if (m_tgt == 0) begin
            m_st = 2;
            if (!m_we) m_rd = '0;
          end else begin
            m_st = 1; m_cnt = 0; starts++;
          end
        end
      end else if (m_st == 1) begin
        if ((m_tgt == 1) ? mem_ack_i : io_ack_i) begin
          if (!m_we) m_rd = (m_tgt == 1) ? b_rd(mem_dat_i, m_sz, m_addr[1:0], MEM_P)
                                         : b_rd(io_dat_i, m_sz, m_addr[1:0], IO_P);
          m_st = 2;
        end else if (m_cnt == TMO - 1) begin
          if (!m_we) m_rd = '0;
          m_st = 2;
        end else m_cnt++;
      end else if (m_st == 2) m_st = 3;
      else if (syn2[2]) m_st = 0;
      syn2 = syn1;
      syn1 = {ext_cs_n, ext_oe_n, ext_we_n};
    end
  end

  // compare, slave response, watchdog
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(mem_cyc_o == (m_st == 1 && m_tgt == 1) && mem_stb_o == mem_cyc_o, "R1 mem cyc/stb", 32'(mem_cyc_o), 32'(m_st == 1 && m_tgt == 1));
      chk(io_cyc_o == (m_st == 1 && m_tgt == 2) && io_stb_o == io_cyc_o, "R2 io cyc/stb", 32'(io_cyc_o), 32'(m_st == 1 && m_tgt == 2));
      chk(ext_wait == (m_st == 1), "R5 wait", 32'(ext_wait), 32'(m_st == 1));
      chk(ext_ready == (m_st == 2), "R5 ready", 32'(ext_ready), 32'(m_st == 2));
      chk(ext_rdata == m_rd, "R12 rdata", ext_rdata, m_rd);
      chk(ext_clk_o == clk && ext_irq_o == irq_i, "R10 passthrough", 32'(ext_irq_o), 32'(irq_i));
      if (m_st == 1 && m_cnt == 0) begin
        if (m_tgt == 1) begin
          chk(mem_adr_o == m_addr[31:2], "R3 mem adr", 32'(mem_adr_o), 32'(m_addr[31:2]));
          chk(mem_sel_o == b_sel(m_sz, m_addr[1:0], MEM_P), "R8 mem sel", 32'(mem_sel_o), 32'(b_sel(m_sz, m_addr[1:0], MEM_P)));
          chk(mem_we_o == m_we, "R4 mem we", 32'(mem_we_o), 32'(m_we));
          if (m_we) chk(mem_dat_o == b_wd(m_wd, m_sz, m_addr[1:0], MEM_P), "R8 mem wdat", mem_dat_o, b_wd(m_wd, m_sz, m_addr[1:0], MEM_P));
        end else begin
          chk(io_adr_o == m_addr[31:2], "R3 io adr", 32'(io_adr_o), 32'(m_addr[31:2]));
          chk(io_sel_o == b_sel(m_sz, m_addr[1:0], IO_P), "R9 io sel", 32'(io_sel_o), 32'(b_sel(m_sz, m_addr[1:0], IO_P)));
          chk(io_we_o == m_we, "R4 io we", 32'(io_we_o), 32'(m_we));
          if (m_we) chk(io_dat_o == b_wd(m_wd, m_sz, m_addr[1:0], IO_P), "R9 io wdat", io_dat_o, b_wd(m_wd, m_sz, m_addr[1:0], IO_P));
        end
      end
    end
    if (mem_cyc_o || io_cyc_o) run_len++;
    else if (run_len != 0) begin last_run = run_len; run_len = 0; end
    mem_ack_i = mem_cyc_o && (mem_cc == mem_lat);
    mem_cc    = mem_cyc_o ? mem_cc + 1 : 0;
    io_ack_i  = io_cyc_o && (io_cc == io_lat);
    io_cc     = io_cyc_o ? io_cc + 1 : 0;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input int hold);
    int n;
    @(negedge clk);
    ext_addr = a; ext_size = sz; ext_wdata = wd; ext_cs_n = 1'b0;
    if (wr) ext_we_n = 1'b0; else ext_oe_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!ext_ready && n < 60);
    chk(ext_ready, "R5 completion seen", 32'(ext_ready), 32'd1);
    repeat (hold) @(negedge clk);
    ext_cs_n = 1'b1; ext_oe_n = 1'b1; ext_we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_cyc_o && !io_cyc_o && !ext_wait && !ext_ready && ext_rdata == 0, "R5 reset state",
        {mem_cyc_o, io_cyc_o, ext_wait, ext_ready, ext_rdata[27:0]}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 word read bank 0
    mem_lat = 2; mem_dat_i = 32'hA1B2_C3D4;
    access(32'h4000_0010, 2'd2, 0, '0, 0);
    chk(ext_rdata == 32'hA1B2_C3D4, "R1 word read", ext_rdata, 32'hA1B2_C3D4);
    chk(last_run == 3, "R6 cyc length lat2", 32'(last_run), 32'd3);

    // R8 byte write bank 3 offset 3, R12 rdata held
    mem_lat = 0;
    access(32'h4C00_0103, 2'd0, 1, 32'h0000_005A, 0);
    chk(ext_rdata == 32'hA1B2_C3D4, "R12 held over write", ext_rdata, 32'hA1B2_C3D4);

    // R8 half read bank 4 offset 2
    mem_lat = 1; mem_dat_i = 32'h1122_3344;
    access(32'h5000_0006, 2'd1, 0, '0, 0);
    chk(ext_rdata == 32'h0000_1122, "R8 half read", ext_rdata, 32'h0000_1122);

    // R8 misaligned word clipped
    mem_lat = 0; mem_dat_i = 32'hCAFE_F00D;
    access(32'h4400_0001, 2'd2, 0, '0, 0);
    chk(ext_rdata == 32'h00CA_FEF0, "R8 clipped word", ext_rdata, 32'h00CA_FEF0);

    // R2 R9 io word read on 16-bit port
    io_lat = 3; io_dat_i = 32'hDEAD_BEEF;
    access(32'h5400_0020, 2'd2, 0, '0, 0);
    chk(ext_rdata == 32'h0000_BEEF, "R9 io narrow read", ext_rdata, 32'h0000_BEEF);

    // R9 io byte write, offset ignored
    io_lat = 0;
    access(32'h5400_0001, 2'd0, 1, 32'h1234_5678, 0);

    // R2 unmapped reads
    access(32'h3000_0000, 2'd2, 0, '0, 0);
    chk(ext_rdata == 32'h0, "R2 unmapped read zero", ext_rdata, 32'h0);
    mem_dat_i = 32'h7777_7777; mem_lat = 0;
    access(32'h4000_0000, 2'd2, 0, '0, 0);
    access(32'h5800_0000, 2'd2, 0, '0, 0);
    chk(ext_rdata == 32'h0, "R2 bank6 read zero", ext_rdata, 32'h0);

    // R7 boundary: ack on last allowed clock
    mem_lat = TMO - 1; mem_dat_i = 32'h0BAD_CAFE;
    access(32'h4800_0000, 2'd2, 0, '0, 0);
    chk(ext_rdata == 32'h0BAD_CAFE, "R7 late ack accepted", ext_rdata, 32'h0BAD_CAFE);
    chk(last_run == TMO, "R7 late ack length", 32'(last_run), 32'(TMO));

    // R7 timeout
    mem_lat = NEVER;
    access(32'h4800_0004, 2'd2, 0, '0, 0);
    chk(ext_rdata == 32'h0, "R7 timeout read zero", ext_rdata, 32'h0);
    chk(last_run == TMO, "R7 timeout length", 32'(last_run), 32'(TMO));
    io_lat = NEVER;
    access(32'h5400_0008, 2'd1, 1, 32'hFFFF, 0);
    chk(last_run == TMO, "R7 io write timeout", 32'(last_run), 32'(TMO));

    // R11 chip select held after completion
    mem_lat = 0; mem_dat_i = 32'h5555_AAAA;
    begin
      int s0;
      s0 = starts;
      access(32'h4000_0040, 2'd2, 0, '0, 12);
      chk(starts == s0 + 1, "R11 single cycle", 32'(starts - s0), 32'd1);
    end

    // R10 interrupt
    irq_i = 1'b1; @(negedge clk);
    chk(ext_irq_o == 1'b1, "R10 irq high", 32'(ext_irq_o), 32'd1);
    irq_i = 1'b0; @(negedge clk);
    chk(ext_irq_o == 1'b0, "R10 irq low", 32'(ext_irq_o), 32'd0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule